// File: doc/BRIEF.md
# DDR SDRAM Mode Register and Burst Column Sequencer

This block keeps the two configuration registers of a double-data-rate SDRAM and turns READ and WRITE commands into column address streams. A mode-set command with bank select 00 writes the main register, which sets the burst length, the burst ordering and the read latency. With bank select 01 it writes the extended register, which holds a DLL-off bit and a reduced-drive bit.

Each READ or WRITE latches a start column built from address bits A9 and A7..A0. Two data words move per clock, one on each edge. The block therefore presents a pair of column addresses per clock: one for the rising-edge word and one for the falling-edge word. The burst wraps inside an aligned block of BL columns, in sequential or interleaved order. A separate timer marks the clock cycle in which the first read word is due. A latency of 2.5 clocks is shown by a half-cycle flag.

Top module: `sdram_mode_burst`

## Requirements
- R1: After reset the block shows burst length 2, sequential order, latency 4 half-clocks (2 clocks), `mode_bad_o`=0, both extended bits 0, `col_valid_o`=0 and `rd_due_o`=0.
- R2: A mode-set command (`cmd_i`=01) with `bank_i`=00 loads the main register from `addr_i`, visible in the next cycle. The fields are: A2..A0 burst length (001=2, 010=4, 011=8), A3 order (0 sequential, 1 interleaved) and A6..A4 latency (010=2, 110=2.5, 011=3 clocks). `burst_len_o` gives the length as a number, and `cas_half_o` gives the latency in half-clocks (4, 5, 6).
- R3: A mode-set command with `bank_i`=01 sets `dll_off_o` from A0 and `drive_weak_o` from A1, and leaves the main register unchanged.
- R4: A mode-set command with `bank_i`=10 or 11 changes neither register. NOP, READ and WRITE (`cmd_i`=00, 10, 11) do not change the registers either.
- R5: An unsupported length or latency code sets `mode_bad_o`. Length then falls back to 2 and latency to 3 clocks (`cas_half_o`=6).
- R6: A READ (10) or WRITE (11) sampled at a rising edge starts a burst in the next cycle. The start column is {A9, A7..A0}. `col_valid_o` stays high for BL/2 cycles and then drops. `burst_wr_o` is 1 for a write burst.
- R7: In burst cycle p, `col_rise_o` carries word 2p and `col_fall_o` carries word 2p+1.
- R8: In sequential order, word k is the start column with its low log2(BL) bits replaced by (start+k) mod BL.
- R9: In interleaved order, word k is the start column with its low log2(BL) bits replaced by (start XOR k).
- R10: A READ or WRITE arriving during a burst restarts the sequence from word 0 of the new start column.
- R11: `rd_due_o` pulses for one cycle: the cycle that begins at the rising edge floor(CL) clocks after the READ was sampled. `rd_due_half_o` rises with it only when CL is 2.5.
- R12: A WRITE, or another READ, arriving while a read-latency count is pending cancels or restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 NOP, 01 mode set, 10 READ, 11 WRITE |
| bank_i | input | 2 | Bank select; picks the register on a mode set |
| addr_i | input | 12 | Address bus A11..A0 |
| burst_len_o | output | 4 | Programmed burst length (2, 4, 8) |
| burst_ilv_o | output | 1 | 1 = interleaved order |
| cas_half_o | output | 3 | Read latency in half-clocks |
| mode_bad_o | output | 1 | Main register holds an unsupported code |
| dll_off_o | output | 1 | Extended register DLL-off bit |
| drive_weak_o | output | 1 | Extended register reduced-drive bit |
| col_valid_o | output | 1 | Burst column pair valid |
| col_rise_o | output | 9 | Column of the rising-edge word |
| col_fall_o | output | 9 | Column of the falling-edge word |
| burst_wr_o | output | 1 | Current burst is a write |
| rd_due_o | output | 1 | First read word due in this cycle |
| rd_due_half_o | output | 1 | That word lands on the falling edge |

## Verification
The bench uses start columns that sit in the middle of an aligned block, so the burst must wrap. A design that carried into the upper column bits, or that mixed up addition and XOR, would produce columns outside the block or in the wrong order. It drops A8 and sets A9 to show whether the column is built from the right address bits. It also restarts a burst after its first pair, which catches a counter that keeps running through a new command. Latency is timed for every code, including 2.5, and against cancel and restart. This exposes a due pulse that comes one cycle late or early, or one that survives a WRITE. Mode sets aimed at banks 10 and 11, and unsupported codes, show whether the register is written by mistake and whether the fallback values apply.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;

    localparam int ADDR_W  = 12;
    localparam int BANK_W  = 2;
    localparam int COL_W   = 9;
    localparam int BEAT_W  = 3;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_MRS = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } cmd_e;

    typedef enum logic {
        BT_SEQ = 1'b0,
        BT_ILV = 1'b1
    } btype_e;

    typedef struct packed {
        logic [1:0] bl_log;   // log2 of burst length
        btype_e     bt;
        logic [2:0] cl_half;  // latency in half clocks
        logic       bad;
    } mode_t;

    function automatic mode_t decode_mode(logic [ADDR_W-1:0] r);
        mode_t m;
        m.bad = 1'b0;
        m.bt  = btype_e'(r[3]);
        case (r[2:0])
            3'b001:  m.bl_log = 2'd1;
            3'b010:  m.bl_log = 2'd2;
            3'b011:  m.bl_log = 2'd3;
            default: begin m.bl_log = 2'd1; m.bad = 1'b1; end
        endcase
        case (r[6:4])
            3'b010:  m.cl_half = 3'd4;
            3'b110:  m.cl_half = 3'd5;
            3'b011:  m.cl_half = 3'd6;
            default: begin m.cl_half = 3'd6; m.bad = 1'b1; end
        endcase
        return m;
    endfunction

    function automatic logic [COL_W-1:0] burst_col(
        logic [COL_W-1:0]  start,
        logic [1:0]        bl_log,
        btype_e            bt,
        logic [BEAT_W-1:0] k
    );
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] kx;
        logic [COL_W-1:0] low;
        mask = COL_W'((9'd1 << bl_log) - 9'd1);
        kx   = {{(COL_W-BEAT_W){1'b0}}, k};
        low  = (bt == BT_ILV) ? (start ^ kx) : (start + kx);
        return (start & ~mask) | (low & mask);
    endfunction

endpackage

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
    import ddr_mode_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_RST = 12'h021
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mode_t             mode_o,
    output logic              dll_off_o,
    output logic              drive_weak_o
);

    logic [ADDR_W-1:0] mr_q;
    logic [1:0]        emr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_q  <= MODE_RST;
            emr_q <= '0;
        end else if (cmd_i == CMD_MRS) begin
            case (bank_i)
                2'b00:   mr_q  <= addr_i;
                2'b01:   emr_q <= addr_i[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        mode_o       = decode_mode(mr_q);
        dll_off_o    = emr_q[0];
        drive_weak_o = emr_q[1];
    end

    AST_MRS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i == CMD_MRS && bank_i == 2'b00) |=> $stable(mr_q)); // R4
    AST_EMR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i == CMD_MRS && bank_i == 2'b01) |=> $stable(emr_q)); // R3
    AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_o.cl_half inside {3'd4, 3'd5, 3'd6}); // R5
    AST_BL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_o.bl_log != 2'd0); // R5

endmodule

// File: rtl/ddr_col_seq.sv
module ddr_col_seq
    import ddr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic [COL_W-1:0] col_i,
    input  mode_t            mode_i,
    output logic             valid_o,
    output logic             wr_o,
    output logic [COL_W-1:0] rise_o,
    output logic [COL_W-1:0] fall_o
);

    logic             active_q;
    logic             wr_q;
    logic [COL_W-1:0] col_q;
    logic [1:0]       bl_log_q;
    btype_e           bt_q;
    logic [1:0]       pair_q;
    logic [1:0]       last_pair;

    always_comb last_pair = 2'((3'd1 << (bl_log_q - 2'd1)) - 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            col_q    <= '0;
            bl_log_q <= 2'd1;
            bt_q     <= BT_SEQ;
            pair_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            wr_q     <= wr_i;
            col_q    <= col_i;
            bl_log_q <= mode_i.bl_log;
            bt_q     <= mode_i.bt;
            pair_q   <= '0;
        end else if (active_q) begin
            if (pair_q == last_pair) active_q <= 1'b0;
            else                     pair_q   <= pair_q + 2'd1;
        end
    end

    always_comb begin
        valid_o = active_q;
        wr_o    = wr_q;
        rise_o  = burst_col(col_q, bl_log_q, bt_q, {pair_q, 1'b0});
        fall_o  = burst_col(col_q, bl_log_q, bt_q, {pair_q, 1'b1});
    end

    AST_PAIR_SAME_BLOCK: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (rise_o[COL_W-1:3] == fall_o[COL_W-1:3])); // R8
    AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (rise_o != fall_o)); // R7
    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && pair_q == last_pair && !start_i) |=> !valid_o); // R6
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && pair_q == 2'd0)); // R10

endmodule

// File: rtl/ddr_lat_timer.sv
module ddr_lat_timer (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic [2:0] cl_half_i,
    output logic       due_o,
    output logic       due_half_o
);

    logic [1:0] cnt_q;
    logic       half_q;
    logic       due_q;
    logic       due_half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            half_q     <= 1'b0;
            due_q      <= 1'b0;
            due_half_q <= 1'b0;
        end else begin
            due_q      <= (cnt_q == 2'd1) && !rd_i && !wr_i;
            due_half_q <= (cnt_q == 2'd1) && !rd_i && !wr_i && half_q;
            if (rd_i) begin
                cnt_q  <= cl_half_i[2:1];
                half_q <= cl_half_i[0];
            end else if (wr_i) begin
                cnt_q  <= '0;
            end else if (cnt_q != 2'd0) begin
                cnt_q  <= cnt_q - 2'd1;
            end
        end
    end

    assign due_o      = due_q;
    assign due_half_o = due_half_q;

    AST_DUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        due_o |=> !due_o); // R11
    AST_DUE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !due_o); // R12

endmodule

// File: rtl/sdram_mode_burst.sv
module sdram_mode_burst
    import ddr_mode_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_RST = 12'h021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [3:0]        burst_len_o,
    output logic              burst_ilv_o,
    output logic [2:0]        cas_half_o,
    output logic              mode_bad_o,
    output logic              dll_off_o,
    output logic              drive_weak_o,
    output logic              col_valid_o,
    output logic [COL_W-1:0]  col_rise_o,
    output logic [COL_W-1:0]  col_fall_o,
    output logic              burst_wr_o,
    output logic              rd_due_o,
    output logic              rd_due_half_o
);

    cmd_e             cmd;
    mode_t            mode;
    logic             is_rd;
    logic             is_wr;
    logic [COL_W-1:0] start_col;

    always_comb begin
        cmd       = cmd_e'(cmd_i);
        is_rd     = (cmd == CMD_RD);
        is_wr     = (cmd == CMD_WR);
        start_col = {addr_i[9], addr_i[7:0]};
    end

    ddr_mode_regs #(.MODE_RST(MODE_RST)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .bank_i       (bank_i),
        .addr_i       (addr_i),
        .mode_o       (mode),
        .dll_off_o    (dll_off_o),
        .drive_weak_o (drive_weak_o)
    );

    ddr_col_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (is_rd || is_wr),
        .wr_i    (is_wr),
        .col_i   (start_col),
        .mode_i  (mode),
        .valid_o (col_valid_o),
        .wr_o    (burst_wr_o),
        .rise_o  (col_rise_o),
        .fall_o  (col_fall_o)
    );

    ddr_lat_timer u_lat (
        .clk        (clk),
        .rst        (rst),
        .rd_i       (is_rd),
        .wr_i       (is_wr),
        .cl_half_i  (mode.cl_half),
        .due_o      (rd_due_o),
        .due_half_o (rd_due_half_o)
    );

    always_comb begin
        burst_len_o = 4'd1 << mode.bl_log;
        burst_ilv_o = (mode.bt == BT_ILV);
        cas_half_o  = mode.cl_half;
        mode_bad_o  = mode.bad;
    end

endmodule

// File: tb/tb_sdram_mode_burst.sv
`timescale 1ns/1ps
module tb_sdram_mode_burst;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [1:0]  bank = 2'b00;
    logic [11:0] addr = '0;
    logic [3:0]  burst_len;
    logic        burst_ilv, mode_bad, dll_off, drive_weak;
    logic [2:0]  cas_half;
    logic        col_valid, burst_wr, rd_due, rd_due_half;
    logic [8:0]  col_rise, col_fall;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_mode_burst dut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .addr_i(addr),
        .burst_len_o(burst_len), .burst_ilv_o(burst_ilv), .cas_half_o(cas_half),
        .mode_bad_o(mode_bad), .dll_off_o(dll_off), .drive_weak_o(drive_weak),
        .col_valid_o(col_valid), .col_rise_o(col_rise), .col_fall_o(col_fall),
        .burst_wr_o(burst_wr), .rd_due_o(rd_due), .rd_due_half_o(rd_due_half)
    );

    task automatic chk(string req, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic [8:0] exp_col(logic [8:0] s, int bl, bit ilv, int k);
        logic [8:0] m, low;
        m   = 9'(bl - 1);
        low = ilv ? (s ^ 9'(k)) : (s + 9'(k));
        return (s & ~m) | (low & m);
    endfunction

    task automatic issue(logic [1:0] c, logic [1:0] b, logic [11:0] a);
        @(negedge clk);
        cmd = c; bank = b; addr = a;
        @(posedge clk);
        #1;
        cmd = 2'b00; bank = 2'b00; addr = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "burst_len", burst_len, 2);
        chk("R1", "ilv", burst_ilv, 0);
        chk("R1", "cas_half", cas_half, 4);
        chk("R1", "bad", mode_bad, 0);
        chk("R1", "dll_off", dll_off, 0);
        chk("R1", "weak", drive_weak, 0);
        chk("R1", "col_valid", col_valid, 0);
        chk("R1", "rd_due", rd_due, 0);
    endtask

    task automatic t_mode(logic [11:0] code, int bl, bit ilv, int clh);
        issue(2'b01, 2'b00, code);
        @(negedge clk);
        chk("R2", "burst_len", burst_len, bl);
        chk("R2", "ilv", burst_ilv, ilv);
        chk("R2", "cas_half", cas_half, clh);
        chk("R2", "bad", mode_bad, 0);
    endtask

    // burst check: start column is {A9, A7..A0}
    task automatic t_burst(string req, logic [1:0] c, logic [11:0] a, int bl, bit ilv);
        logic [8:0] s;
        s = {a[9], a[7:0]};
        issue(c, 2'b00, a);
        for (int p = 0; p < bl / 2; p++) begin
            @(negedge clk);
            chk("R6", "col_valid", col_valid, 1);
            chk("R6", "burst_wr", burst_wr, (c == 2'b11));
            chk(req, "rise (R7)", col_rise, exp_col(s, bl, ilv, 2 * p));
            chk(req, "fall (R7)", col_fall, exp_col(s, bl, ilv, 2 * p + 1));
        end
        @(negedge clk);
        chk("R6", "col_valid end", col_valid, 0);
    endtask

    task automatic t_restart();
        logic [8:0] sb;
        sb = {1'b0, 8'h3D};
        issue(2'b10, 2'b00, 12'h005);
        @(negedge clk);
        chk("R10", "first pair", col_rise, 5);
        issue(2'b11, 2'b00, 12'h03D);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            chk("R10", "valid", col_valid, 1);
            chk("R10", "wr", burst_wr, 1);
            chk("R10", "rise", col_rise, exp_col(sb, 8, 0, 2 * p));
            chk("R10", "fall", col_fall, exp_col(sb, 8, 0, 2 * p + 1));
        end
        @(negedge clk);
        chk("R10", "end", col_valid, 0);
    endtask

    task automatic t_due(int fl, bit half);
        issue(2'b10, 2'b00, 12'h000);
        for (int n = 1; n <= 5; n++) begin
            @(negedge clk);
            chk("R11", "rd_due", rd_due, (n == fl + 1));
            chk("R11", "rd_due_half", rd_due_half, (n == fl + 1) && half);
        end
    endtask

    task automatic t_due_cancel();
        issue(2'b10, 2'b00, 12'h000);
        issue(2'b11, 2'b00, 12'h000);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            chk("R12", "cancel by write", rd_due, 0);
        end
        // READ then READ one cycle later: pulse moves one cycle later
        issue(2'b10, 2'b00, 12'h000);
        issue(2'b10, 2'b00, 12'h000);
        for (int n = 1; n <= 5; n++) begin
            @(negedge clk);
            chk("R12", "restart by read", rd_due, (n == 4));
        end
    endtask

    task automatic t_ext();
        issue(2'b01, 2'b01, 12'h003);
        @(negedge clk);
        chk("R3", "dll_off", dll_off, 1);
        chk("R3", "weak", drive_weak, 1);
        chk("R3", "mode kept", burst_len, 8);
        issue(2'b01, 2'b01, 12'h002);
        @(negedge clk);
        chk("R3", "dll_off clr", dll_off, 0);
        chk("R3", "weak kept", drive_weak, 1);
    endtask

    task automatic t_ignore();
        issue(2'b01, 2'b10, 12'h7F1);
        @(negedge clk);
        chk("R4", "bank10 len", burst_len, 8);
        chk("R4", "bank10 cas", cas_half, 6);
        chk("R4", "bank10 ext", drive_weak, 1);
        issue(2'b01, 2'b11, 12'h001);
        issue(2'b10, 2'b00, 12'h021);
        @(negedge clk);
        chk("R4", "bank11/read len", burst_len, 8);
        chk("R4", "bank11/read ilv", burst_ilv, 0);
        chk("R4", "bank11 ext", dll_off, 0);
    endtask

    task automatic t_bad();
        issue(2'b01, 2'b00, 12'h020);   // length code 000
        @(negedge clk);
        chk("R5", "bad len flag", mode_bad, 1);
        chk("R5", "len fallback", burst_len, 2);
        chk("R5", "cas ok", cas_half, 4);
        issue(2'b01, 2'b00, 12'h012);   // latency code 001
        @(negedge clk);
        chk("R5", "bad cl flag", mode_bad, 1);
        chk("R5", "cl fallback", cas_half, 6);
        chk("R5", "len ok", burst_len, 4);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        // BL2 seq, CL2 (reset setting), burst with A8 set (dropped)
        t_burst("R8", 2'b10, 12'h1F7, 2, 0);
        t_mode(12'h062, 4, 0, 5);               // BL4 seq CL2.5
        t_burst("R8", 2'b10, 12'h2B5, 4, 0);
        t_mode(12'h033, 8, 0, 6);               // BL8 seq CL3
        t_burst("R8", 2'b11, 12'h0B6, 8, 0);
        t_mode(12'h03B, 8, 1, 6);               // BL8 ilv CL3
        t_burst("R9", 2'b10, 12'h2B5, 8, 1);
        t_mode(12'h06A, 4, 1, 5);               // BL4 ilv CL2.5
        t_burst("R9", 2'b11, 12'h07B, 4, 1);
        t_due(2, 1);
        t_mode(12'h023, 8, 0, 4);               // BL8 seq CL2
        t_due(2, 0);
        t_restart();
        t_mode(12'h033, 8, 0, 6);
        t_due(3, 0);
        t_due_cancel();
        t_ext();
        t_ignore();
        t_bad();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule